// File: doc/BRIEF.md
# Mode-Gated Frame Timestamp Counter

This block keeps a 16-bit free-running count that a CAN-style controller uses to stamp incoming frames. The count can advance on every peripheral clock cycle or only on a per-channel bit-time strobe. Which of the two applies is chosen by a source-select input. Whether the count advances at all is decided each cycle from the controller's global mode, or from the channel's mode, depending on that selection. While the controller sits in its global reset mode the count is held at zero. A halted count keeps its value.

On every start-of-frame indication the block latches the count and raises a one-cycle valid strobe, so a receive buffer or FIFO can store the stamp next to the frame. A 32-bit read port with byte-lane enables returns the live count in the low half-word. The upper half-word always reads as zero.

Top module: `ts_frame_stamp`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0x0000 and `cap_valid` becomes 0. After reset is released, reads return 0 until the count advances.
- R2: When `glb_mode` is 0 (global reset) at a clock edge, the count becomes 0x0000 at that edge. This holds for either source and any channel mode.
- R3: With `src_sel` = 0 and `glb_mode` = 1 (operating), the count rises by one at every clock edge. It wraps from 0xFFFF to 0x0000.
- R4: With `src_sel` = 0 and `glb_mode` = 2 (test) or 3 (stop), the count holds its value. `ch_mode` and `bit_tick` have no effect.
- R5: With `src_sel` = 1 and `glb_mode` not 0, the count rises by one at an edge only when `ch_mode` = 1 (communication) and `bit_tick` is high. In every other case it holds, including `ch_mode` 0 (reset), 2 (halt) and 3 (treated as halt).
- R6: A high `sof` at a clock edge loads `cap_value` with the count as it was before that edge, so any increment at the same edge is excluded. `cap_valid` is high for exactly the following cycle. Without `sof`, `cap_valid` is low and `cap_value` holds.
- R7: With `rd_en` high and `rd_be` = 4'hF, `rd_data[15:0]` equals the live count and `rd_data[31:16]` is zero.
- R8: `rd_be[i]` enables byte lane i, which is `rd_data[8*i+7:8*i]`. A lane that is not enabled reads zero, and `rd_data` is all zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Count source: 0 = peripheral clock, 1 = channel bit-time strobe |
| glb_mode | input | 2 | Global mode: 0 reset, 1 operating, 2 test, 3 stop |
| ch_mode | input | 2 | Channel mode: 0 reset, 1 communication, 2 halt, 3 halt |
| bit_tick | input | 1 | One-cycle bit-time strobe, synchronous to `clk` |
| sof | input | 1 | Start-of-frame detected |
| rd_en | input | 1 | Read access strobe |
| rd_be | input | 4 | Byte-lane enables for the read |
| rd_data | output | 32 | Read data: live count in bits 15:0, zero above |
| cap_value | output | 16 | Count latched at the last start-of-frame |
| cap_valid | output | 1 | High for one cycle after a capture |

## Verification
The assertions assume that the mode inputs, `bit_tick` and `sof` are already synchronous to `clk` and settle between edges. They also assume that `bit_tick` is a strobe and not a level that a slower clock domain stretches. The bench drives every input one time unit after the rising edge, from tasks, and so never changes them near an edge. It sweeps every combination of source, global mode, channel mode (including the unused code 3), tick and start-of-frame against an arithmetic model. It runs the count through its wrap. It then walks all sixteen byte-enable patterns with the read strobe both high and low.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int TS_CNT_W  = 16;
    localparam int TS_DATA_W = 32;

    typedef enum logic [1:0] {
        GM_RESET = 2'd0,
        GM_OPER  = 2'd1,
        GM_TEST  = 2'd2,
        GM_STOP  = 2'd3
    } glb_mode_e;

    typedef enum logic [1:0] {
        CM_RESET = 2'd0,
        CM_COMM  = 2'd1,
        CM_HALT  = 2'd2,
        CM_SPARE = 2'd3
    } ch_mode_e;

    typedef enum logic {
        SRC_PCLK = 1'b0,
        SRC_BITT = 1'b1
    } cnt_src_e;

    // Per-cycle decision handed from the run controller to the counter.
    typedef struct packed {
        logic clear;
        logic advance;
    } run_cmd_t;

    // Decide whether the count advances this cycle, given the source and modes.
    function automatic logic run_advance(cnt_src_e src, glb_mode_e gm,
                                         ch_mode_e cm, logic tick);
        logic adv;
        if (gm == GM_RESET) begin
            adv = 1'b0;
        end else if (src == SRC_PCLK) begin
            adv = (gm == GM_OPER);
        end else begin
            adv = (cm == CM_COMM) && tick;
        end
        return adv;
    endfunction

endpackage

// File: rtl/ts_run_ctrl.sv
module ts_run_ctrl
    import ts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cnt_src_e  src,
    input  glb_mode_e gm,
    input  ch_mode_e  cm,
    input  logic      tick,
    output run_cmd_t  cmd
);

    always_comb begin
        cmd.clear   = (gm == GM_RESET);
        cmd.advance = run_advance(src, gm, cm, tick);
    end

    // R4: with the clock source, no advance outside operating mode
    p_pclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PCLK && gm != GM_OPER) |-> !cmd.advance);

    // R5: with the bit-time source, no advance without a tick in comm mode
    p_bitt_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_BITT && !(tick && cm == CM_COMM)) |-> !cmd.advance);

    // R2: clear and advance never requested together
    p_clear_excl_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |-> !cmd.advance);

endmodule

// File: rtl/ts_counter.sv
module ts_counter
    import ts_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  run_cmd_t         cmd,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            count <= '0;
        end else if (cmd.advance) begin
            count <= count + ONE;
        end
    end

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (count == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clear && cmd.advance) |=> (count == $past(count) + ONE));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clear && !cmd.advance) |=> $stable(count));

endmodule

// File: rtl/ts_capture.sv
module ts_capture
    import ts_pkg::*;
#(
    parameter int CNT_W = TS_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_value <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= sof;
            if (sof) begin
                cap_value <= count;
            end
        end
    end

    // R6: stamp is the pre-edge count, strobe lasts one cycle
    p_stamp_r6: assert property (@(posedge clk) disable iff (rst)
        sof |=> (cap_valid && cap_value == $past(count)));

    p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !sof |=> (!cap_valid && $stable(cap_value)));

endmodule

// File: rtl/ts_read_port.sv
module ts_read_port
    import ts_pkg::*;
#(
    parameter int CNT_W  = TS_CNT_W,
    parameter int DATA_W = TS_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [DATA_W/8-1:0] rd_be,
    input  logic [CNT_W-1:0]    count,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] word;
    assign word = {{(DATA_W-CNT_W){1'b0}}, count};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_data[8*i +: 8] = (rd_en && rd_be[i]) ? word[8*i +: 8] : 8'h00;
    end

    // R7: the bits above the count never carry data
    always_comb begin
        if (!rst) begin
            a_upper_zero_r7: assert (rd_data[DATA_W-1:CNT_W] == '0);
        end
    end

    // R8: an idle read port drives nothing
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

endmodule

// File: rtl/ts_frame_stamp.sv
module ts_frame_stamp
    import ts_pkg::*;
#(
    parameter int CNT_W  = TS_CNT_W,
    parameter int DATA_W = TS_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_sel,
    input  logic [1:0]          glb_mode,
    input  logic [1:0]          ch_mode,
    input  logic                bit_tick,
    input  logic                sof,
    input  logic                rd_en,
    input  logic [DATA_W/8-1:0] rd_be,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CNT_W-1:0]    cap_value,
    output logic                cap_valid
);

    run_cmd_t         cmd;
    logic [CNT_W-1:0] count;

    ts_run_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .src  (cnt_src_e'(src_sel)),
        .gm   (glb_mode_e'(glb_mode)),
        .cm   (ch_mode_e'(ch_mode)),
        .tick (bit_tick),
        .cmd  (cmd)
    );

    ts_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .count (count)
    );

    ts_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .count     (count),
        .cap_value (cap_value),
        .cap_valid (cap_valid)
    );

    ts_read_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_be   (rd_be),
        .count   (count),
        .rd_data (rd_data)
    );

    // R1: reset leaves no stale strobe behind
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!cap_valid && cap_value == '0));

endmodule

// File: tb/tb_ts_frame_stamp.sv
`timescale 1ns/1ps
module tb_ts_frame_stamp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_sel = 1'b0;
    logic [1:0]  glb_mode = 2'd0;
    logic [1:0]  ch_mode = 2'd0;
    logic        bit_tick = 1'b0;
    logic        sof = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_be = 4'h0;
    logic [31:0] rd_data;
    logic [15:0] cap_value;
    logic        cap_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_cnt = 16'h0;
    logic [15:0] exp_cap = 16'h0;
    logic        exp_vld = 1'b0;

    always #5 clk = ~clk;

    ts_frame_stamp dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .glb_mode(glb_mode),
        .ch_mode(ch_mode), .bit_tick(bit_tick), .sof(sof), .rd_en(rd_en),
        .rd_be(rd_be), .rd_data(rd_data), .cap_value(cap_value),
        .cap_valid(cap_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the next count from the inputs present at the coming edge.
    function automatic logic [15:0] next_cnt(logic [15:0] c);
        if (rst || glb_mode == 2'd0) return 16'h0;
        if (!src_sel) return (glb_mode == 2'd1) ? c + 16'h1 : c;
        return (ch_mode == 2'd1 && bit_tick) ? c + 16'h1 : c;
    endfunction

    task automatic step();
        logic [15:0] n;
        n = next_cnt(exp_cnt);
        if (rst) begin
            exp_cap = 16'h0;
            exp_vld = 1'b0;
        end else begin
            exp_vld = sof;
            if (sof) exp_cap = exp_cnt;
        end
        @(posedge clk);
        #1;
        exp_cnt = n;
    endtask

    task automatic read_cnt(input string req);
        rd_en = 1'b1;
        rd_be = 4'hF;
        #1;
        chk(req, rd_data, {16'h0, exp_cnt});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        glb_mode = 2'd1;
        sof = 1'b1;
        step();
        step();
        rst = 1'b0;
        sof = 1'b0;
        glb_mode = 2'd2;
        step();
        read_cnt("R1 count after reset");
        chk("R1 cap_valid after reset", {31'h0, cap_valid}, 32'h0);
        chk("R1 cap_value after reset", {16'h0, cap_value}, 32'h0);

        // Near-exhaustive sweep of source, modes, tick and sof (R2 R4 R5 R6)
        for (int rep = 0; rep < 2; rep++) begin
            for (int s = 0; s < 2; s++) begin
                for (int g = 0; g < 4; g++) begin
                    for (int c = 0; c < 4; c++) begin
                        for (int t = 0; t < 2; t++) begin
                            for (int f = 0; f < 2; f++) begin
                                // preload a nonzero count in operating mode
                                src_sel = 1'b0; glb_mode = 2'd1; sof = 1'b0; bit_tick = 1'b0;
                                step(); step(); step();
                                src_sel = 1'(s); glb_mode = 2'(g); ch_mode = 2'(c);
                                bit_tick = 1'(t); sof = 1'(f);
                                step();
                                sof = 1'b0; bit_tick = 1'b0; glb_mode = 2'd2; src_sel = 1'b0;
                                read_cnt(g == 0 ? "R2 clear in global reset" :
                                         (s == 0 ? "R4 clock source gating" : "R5 bit-time gating"));
                                chk("R6 cap_valid", {31'h0, cap_valid}, {31'h0, exp_vld});
                                chk("R6 cap_value", {16'h0, cap_value}, {16'h0, exp_cap});
                                step();
                                chk("R6 strobe one cycle", {31'h0, cap_valid}, 32'h0);
                            end
                        end
                    end
                end
            end
        end

        // R3: run to the wrap in operating mode
        glb_mode = 2'd0;
        step();
        src_sel = 1'b0;
        glb_mode = 2'd1;
        for (int k = 0; k < 65535; k++) step();
        read_cnt("R3 count at 0xFFFF");
        chk("R3 model reached top", {16'h0, exp_cnt}, 32'h0000_FFFF);
        sof = 1'b1;
        step();
        sof = 1'b0;
        read_cnt("R3 wrap to zero");
        chk("R6 capture before wrap", {16'h0, cap_value}, 32'h0000_FFFF);
        chk("R6 capture strobe at wrap", {31'h0, cap_valid}, 32'h1);

        // R7 R8: byte lanes with a count that fills both low bytes
        glb_mode = 2'd0;
        step();
        glb_mode = 2'd1;
        for (int k = 0; k < 16'h1234; k++) step();
        glb_mode = 2'd3;
        step();
        read_cnt("R7 live count");
        chk("R7 upper half zero", {16'h0, rd_data[31:16]}, 32'h0);
        for (int e = 0; e < 2; e++) begin
            for (int b = 0; b < 16; b++) begin
                logic [31:0] m;
                rd_en = 1'(e);
                rd_be = 4'(b);
                #1;
                m = 32'h0;
                for (int l = 0; l < 4; l++) if (b[l]) m[8*l +: 8] = 8'hFF;
                chk("R8 byte lanes", rd_data, (e == 1) ? (m & {16'h0, exp_cnt}) : 32'h0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule